// File: doc/BRIEF.md
# Smart Card Transmit-End and Parity Status Flags

This block holds the two sticky status flags of a half-duplex smart card character transmitter: a transmit-end flag and a parity-error flag. The transmit-end flag reports that the card has raised no error signal and the transmitter is ready to take its next byte. It is raised a fixed number of element time units (etu) after each character starts. The delay depends on the guard-time mode and the block-transfer mode. While the transmitter is disabled and no error signal is flagged, the transmit-end flag is held high.

The delay is measured with a strobe that runs at twice the etu rate. Half-etu delays therefore become whole tick counts. Software clears either flag in two steps: a status read that sees the relevant bit at 1, then a status write that puts 0 in that bit. A transfer agent that reloads the data register can also clear the transmit-end flag directly with a pulse. When a set and a clear meet in the same cycle, the set wins.

Top module: `sc_txend_flags`

## Requirements
- R1: After reset, `tx_end` is 1 and `parity_err` is 0.
- R2: While `tx_en` is 0 and `err_sig` is 0, `tx_end` is 1 from the next cycle on.
- R3: After a `char_start` pulse, `tx_end` rises in the cycle after the Nth `half_etu_tick` pulse, where N is 2 when `guard_mode` is 1, 3 when `guard_mode` is 0 and `block_mode` is 1, and 5 when both are 0. The mode is the one sampled at `char_start`. The rise happens only if `err_sig` is 0 and `tdr_empty` is 1 in the cycle of the Nth tick.
- R4: If `err_sig` is 1 or `tdr_empty` is 0 in the cycle of the Nth tick, the timed set is dropped and `tx_end` stays 0 for that character.
- R5: A new `char_start` restarts the tick count from zero and cancels any timed set still pending from the earlier character.
- R6: A write with `wr_data[0]`=0 clears `tx_end` only if the previous write was followed by a read made while `tdr_empty` was 1. Any write consumes the arming.
- R7: A `xfer_load` pulse clears `tx_end` in the next cycle.
- R8: A `rx_parity_err` pulse sets `parity_err`. A write with `wr_data[2]`=0 clears it only if, since the previous write, a read has seen `parity_err` at 1.
- R9: A write of 0 with no armed read leaves the flag unchanged. Writing 1 to either flag bit leaves that flag unchanged.
- R10: When a set condition and a clear meet in the same cycle, the flag ends up 1.
- R11: `rd_data` is {`parity_err`, `tx_end`, `tdr_empty`}, with bit 2 the parity flag and bit 0 the data-register-empty flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmitter enable |
| err_sig | input | 1 | Error-signal flag from the line monitor |
| tdr_empty | input | 1 | Transmit data register empty flag |
| guard_mode | input | 1 | Guard-time mode select |
| block_mode | input | 1 | Block-transfer mode select |
| char_start | input | 1 | One-cycle pulse at the start of a character |
| half_etu_tick | input | 1 | One-cycle pulse, twice per etu |
| rx_parity_err | input | 1 | Parity error pulse from the receiver |
| xfer_load | input | 1 | Transfer agent loaded the next byte |
| rd_en | input | 1 | Status read strobe |
| wr_en | input | 1 | Status write strobe |
| wr_data | input | 3 | Status write data |
| rd_data | output | 3 | Status read data |
| tx_end | output | 1 | Transmit-end flag |
| parity_err | output | 1 | Parity-error flag |

## Verification
The bench builds the block with its default parameters: a 4-bit tick counter, delays of 5, 3 and 2 half-etu ticks, and the mode latched at character start. With these values the bench can sweep all four mode combinations tick by tick. Before each tick it checks that `tx_end` is still low, and after the last tick it checks that `tx_end` is high. It repeats the sweep with each set condition blocked and with a restart one tick short of expiry. The small counter also places the overflow guard within reach of elaboration.

// File: rtl/sc_txend_pkg.sv
package sc_txend_pkg;
   typedef enum logic [1:0] {
      DLY_NORMAL = 2'd0,
      DLY_BLOCK  = 2'd1,
      DLY_GUARD  = 2'd2
   } dly_sel_e;

   localparam int unsigned RD_BIT_TDRE = 0;
   localparam int unsigned RD_BIT_TEND = 1;
   localparam int unsigned RD_BIT_PERR = 2;
   localparam int unsigned STATUS_W    = 3;

   function automatic dly_sel_e pick_delay(input logic guard, input logic blk);
      if (guard)    return DLY_GUARD;
      else if (blk) return DLY_BLOCK;
      else          return DLY_NORMAL;
   endfunction
endpackage

// File: rtl/sc_etu_delay_timer.sv
module sc_etu_delay_timer
   import sc_txend_pkg::*;
#(
   parameter int unsigned CNT_W       = 4,
   parameter int unsigned HALF_NORMAL = 5,
   parameter int unsigned HALF_BLOCK  = 3,
   parameter int unsigned HALF_GUARD  = 2,
   parameter bit          LATCH_MODE  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic char_start,
   input  logic half_etu_tick,
   input  logic guard_mode,
   input  logic block_mode,
   output logic expire
);
   localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

   generate
      if (HALF_NORMAL == 0 || HALF_BLOCK == 0 || HALF_GUARD == 0) begin : g_bad_zero
         $error("sc_etu_delay_timer: delays must be non-zero");
      end
      if (HALF_NORMAL > CNT_MAX || HALF_BLOCK > CNT_MAX || HALF_GUARD > CNT_MAX) begin : g_bad_width
         $error("sc_etu_delay_timer: CNT_W too narrow for a delay");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nx;
   logic             active_q;
   dly_sel_e         sel_q;
   dly_sel_e         sel_use;
   logic [CNT_W-1:0] target;

   generate
      if (LATCH_MODE) begin : g_latched
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          sel_q <= DLY_NORMAL;
            else if (char_start) sel_q <= pick_delay(guard_mode, block_mode);
         end
         assign sel_use = sel_q;
      end else begin : g_live
         assign sel_q   = DLY_NORMAL;
         assign sel_use = pick_delay(guard_mode, block_mode);
      end
   endgenerate

   always_comb begin
      unique case (sel_use)
         DLY_GUARD: target = CNT_W'(HALF_GUARD);
         DLY_BLOCK: target = CNT_W'(HALF_BLOCK);
         default:   target = CNT_W'(HALF_NORMAL);
      endcase
   end

   assign cnt_nx = cnt_q + 1'b1;
   assign expire = active_q && half_etu_tick && !char_start && (cnt_nx == target);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         active_q <= 1'b0;
      end else if (char_start) begin
         cnt_q    <= '0;
         active_q <= 1'b1;
      end else if (active_q && half_etu_tick) begin
         cnt_q <= cnt_nx;
         if (cnt_nx == target) active_q <= 1'b0;
      end
   end

   AST_EXPIRE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !active_q); // R3
   AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      char_start |=> (active_q && cnt_q == '0)); // R5
endmodule

// File: rtl/sc_sticky_flag.sv
module sc_sticky_flag #(
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic arm_rd_i,
   input  logic wr_i,
   input  logic wr_zero_i,
   input  logic clr_direct_i,
   output logic flag_o
);
   logic armed_q;
   logic clr;

   assign clr = (wr_i && wr_zero_i && armed_q) || clr_direct_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        armed_q <= 1'b0;
      else if (wr_i)     armed_q <= 1'b0;
      else if (arm_rd_i) armed_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_o <= RST_VAL;
      else if (set_i) flag_o <= 1'b1;
      else if (clr)   flag_o <= 1'b0;
   end

   AST_NO_BLIND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !armed_q && !clr_direct_i) |=> flag_o); // R9
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o); // R10
endmodule

// File: rtl/sc_txend_flags.sv
module sc_txend_flags
   import sc_txend_pkg::*;
#(
   parameter int unsigned CNT_W       = 4,
   parameter int unsigned HALF_NORMAL = 5,
   parameter int unsigned HALF_BLOCK  = 3,
   parameter int unsigned HALF_GUARD  = 2,
   parameter bit          LATCH_MODE  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tx_en,
   input  logic                err_sig,
   input  logic                tdr_empty,
   input  logic                guard_mode,
   input  logic                block_mode,
   input  logic                char_start,
   input  logic                half_etu_tick,
   input  logic                rx_parity_err,
   input  logic                xfer_load,
   input  logic                rd_en,
   input  logic                wr_en,
   input  logic [STATUS_W-1:0] wr_data,
   output logic [STATUS_W-1:0] rd_data,
   output logic                tx_end,
   output logic                parity_err
);
   logic expire;
   logic tend_set;

   sc_etu_delay_timer #(
      .CNT_W(CNT_W), .HALF_NORMAL(HALF_NORMAL), .HALF_BLOCK(HALF_BLOCK),
      .HALF_GUARD(HALF_GUARD), .LATCH_MODE(LATCH_MODE)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .char_start(char_start),
      .half_etu_tick(half_etu_tick), .guard_mode(guard_mode),
      .block_mode(block_mode), .expire(expire)
   );

   assign tend_set = (!tx_en && !err_sig) || (expire && !err_sig && tdr_empty);

   sc_sticky_flag #(.RST_VAL(1'b1)) u_tend (
      .clk(clk), .rst_n(rst_n), .set_i(tend_set),
      .arm_rd_i(rd_en && tdr_empty), .wr_i(wr_en),
      .wr_zero_i(!wr_data[RD_BIT_TDRE]), .clr_direct_i(xfer_load),
      .flag_o(tx_end)
   );

   sc_sticky_flag #(.RST_VAL(1'b0)) u_perr (
      .clk(clk), .rst_n(rst_n), .set_i(rx_parity_err),
      .arm_rd_i(rd_en && parity_err), .wr_i(wr_en),
      .wr_zero_i(!wr_data[RD_BIT_PERR]), .clr_direct_i(1'b0),
      .flag_o(parity_err)
   );

   always_comb begin
      rd_data              = '0;
      rd_data[RD_BIT_TDRE] = tdr_empty;
      rd_data[RD_BIT_TEND] = tx_end;
      rd_data[RD_BIT_PERR] = parity_err;
   end

   AST_LEVEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_en && !err_sig) |=> tx_end); // R2
   AST_TIMED_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !err_sig && tdr_empty) |=> tx_end); // R3
   AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_load && tx_en && !expire) |=> !tx_end); // R7
   AST_PERR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_parity_err |=> parity_err); // R8
   AST_WR1_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[RD_BIT_PERR] && parity_err) |=> parity_err); // R9
endmodule

// File: tb/sc_txend_flags_bench.sv
module sc_txend_flags_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_en = 1'b0, err_sig = 1'b0, tdr_empty = 1'b1;
   logic guard_mode = 1'b0, block_mode = 1'b0;
   logic char_start = 1'b0, half_etu_tick = 1'b0;
   logic rx_parity_err = 1'b0, xfer_load = 1'b0;
   logic rd_en = 1'b0, wr_en = 1'b0;
   logic [2:0] wr_data = 3'b111;
   logic [2:0] rd_data;
   logic tx_end, parity_err;

   int checks = 0;
   int fails = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   sc_txend_flags u_sc_txend_flags (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .err_sig(err_sig),
      .tdr_empty(tdr_empty), .guard_mode(guard_mode), .block_mode(block_mode),
      .char_start(char_start), .half_etu_tick(half_etu_tick),
      .rx_parity_err(rx_parity_err), .xfer_load(xfer_load),
      .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .tx_end(tx_end), .parity_err(parity_err)
   );

   task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_read();
      rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic do_write(input logic [2:0] d);
      wr_data = d; wr_en = 1'b1; @(negedge clk); wr_en = 1'b0; wr_data = 3'b111;
   endtask

   task automatic tick();
      half_etu_tick = 1'b1; @(negedge clk); half_etu_tick = 1'b0; @(negedge clk);
   endtask

   task automatic start_char();
      char_start = 1'b1; @(negedge clk); char_start = 1'b0;
   endtask

   task automatic clear_tend();
      tdr_empty = 1'b1; do_read(); do_write(3'b110);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=%0d expected<=20000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int n;
      @(negedge clk);
      check("R1 tx_end reset", {2'b0, tx_end}, 3'b001);
      check("R1 parity_err reset", {2'b0, parity_err}, 3'b000);
      rst_n = 1'b1;
      idle(1);
      check("R2 level set holds", {2'b0, tx_end}, 3'b001);
      tx_en = 1'b1;
      clear_tend();
      check("R6 armed write clears", {2'b0, tx_end}, 3'b000);
      tx_en = 1'b0; idle(1);
      check("R2 level set", {2'b0, tx_end}, 3'b001);
      tx_en = 1'b1;

      for (int m = 0; m < 4; m++) begin
         for (int blk = 0; blk < 2; blk++) begin
            guard_mode = m[1]; block_mode = m[0];
            n = m[1] ? 2 : (m[0] ? 3 : 5);
            clear_tend();
            err_sig = (blk == 1);
            start_char();
            guard_mode = ~guard_mode;
            for (int k = 1; k <= n; k++) begin
               check("R3 no early set", {2'b0, tx_end}, 3'b000);
               tick();
            end
            if (blk == 0) check("R3 set at tick N", {2'b0, tx_end}, 3'b001);
            else          check("R4 err_sig blocks set", {2'b0, tx_end}, 3'b000);
            err_sig = 1'b0;
         end
      end

      guard_mode = 1'b0; block_mode = 1'b1;
      clear_tend();
      start_char();
      tick(); tick();
      tdr_empty = 1'b0;
      tick();
      check("R4 tdr_empty=0 blocks set", {2'b0, tx_end}, 3'b000);
      tdr_empty = 1'b1;
      tick();
      check("R4 no late set", {2'b0, tx_end}, 3'b000);

      start_char();
      tick(); tick();
      start_char();
      tick(); tick();
      check("R5 restart cancels", {2'b0, tx_end}, 3'b000);
      tick();
      check("R5 set after restart", {2'b0, tx_end}, 3'b001);

      xfer_load = 1'b1; @(negedge clk); xfer_load = 1'b0;
      check("R7 load clears", {2'b0, tx_end}, 3'b000);

      tx_en = 1'b0; idle(1); tx_en = 1'b1;
      do_write(3'b000);
      check("R9 unarmed write keeps tx_end", {2'b0, tx_end}, 3'b001);
      tdr_empty = 1'b0; do_read(); tdr_empty = 1'b1; do_write(3'b000);
      check("R6 read with tdr_empty=0 not armed", {2'b0, tx_end}, 3'b001);
      do_read(); do_write(3'b111);
      check("R9 write 1 keeps tx_end", {2'b0, tx_end}, 3'b001);
      do_write(3'b000);
      check("R6 arming consumed", {2'b0, tx_end}, 3'b001);

      rx_parity_err = 1'b1; @(negedge clk); rx_parity_err = 1'b0;
      check("R8 parity set", {2'b0, parity_err}, 3'b001);
      check("R11 read layout", rd_data, {parity_err, tx_end, tdr_empty});
      check("R11 read value", rd_data, 3'b111);
      do_write(3'b000);
      check("R9 unarmed write keeps parity", {2'b0, parity_err}, 3'b001);
      do_read(); do_write(3'b100);
      check("R9 write 1 keeps parity", {2'b0, parity_err}, 3'b001);
      do_read();
      rx_parity_err = 1'b1; do_write(3'b000); rx_parity_err = 1'b0;
      check("R10 parity set wins", {2'b0, parity_err}, 3'b001);
      do_read(); do_write(3'b011);
      check("R8 armed write clears parity", {2'b0, parity_err}, 3'b000);

      clear_tend();
      do_read();
      tx_en = 1'b0; do_write(3'b000); tx_en = 1'b1;
      check("R10 tx_end set wins", {2'b0, tx_end}, 3'b001);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule